// File: doc/BRIEF.md
# Programmable skew clock bank generator

This block builds four banks of two clock outputs from one fast timing clock. The timing clock runs at sixteen times the nominal output frequency, so one tick of it is one timing unit (tU). Every bank has a pair of three-level select inputs. The pair picks either a signed phase offset in whole tU steps or a special waveform: divide-by-2, divide-by-4 or inversion. The special waveforms exist only in banks 3 and 4.

A synchronous stop input, an edge-polarity input and a test-mode input control gating. A stop takes effect only on a boundary where the gated output is already at its rest level, and every output is a register, so no output ever produces a shortened pulse. Bank 3 is the feedback pair. It keeps running during a normal stop so that an outer phase loop stays locked.

Each three-level input is carried on two wires: 00 is LOW, 01 is MID, 10 is HIGH, and 11 (an undriven input) reads as MID. Bank n (n = 1..4) takes its selects from `bank_sel_i[4n-1:4n-4]`. The upper wire pair of that slice is the first letter of the code and the lower pair is the second letter. Bank n drives `clk_o[2n-1:2n-2]`.

Top module: `skew_clock_banks`

## Requirements
- R1: While `rst` is high, all `clk_o` bits are low from the next edge onward.
- R2: A phase count c is 0 at the first rising edge after reset release and then increments by one each edge, modulo 64. After edge k the outputs reflect c = k-1. An undivided output with skew s is high when (c - s) mod 16 < 8. Both pins of a bank are always equal.
- R3: For banks 1 and 2, the nine codes LL, LM, LH, ML, MM, MH, HL, HM, HH give skews -4, -3, -2, -1, 0, +1, +2, +3, +4 tU in that order.
- R4: For banks 3 and 4, codes LM through HM give skews -6, -4, -2, 0, +2, +4, +6 tU in that order.
- R5: In banks 3 and 4, LL selects divide-by-2, which is high when (c - d) mod 32 < 16. In bank 3, HH selects divide-by-4, which is high when (c - d) mod 64 < 32. Here d = 0 with the polarity input high and d = 8 with it low.
- R6: In bank 4, HH gives the zero-skew waveform inverted, that is, high when c mod 16 >= 8.
- R7: The polarity input moves only the divided waveforms (by 8 ticks, onto the falling reference edge). The rising edges of divide-by-2 and divide-by-4 still coincide. Undivided and inverted outputs do not depend on it.
- R8: A select or test wire pair of 11 behaves exactly like 01 (MID).
- R9: With stop high and test not MID, banks 1, 2 and 4 rest LOW while bank 3 keeps running, in any mode.
- R10: When bank 4 is inverted and stopped, it rests at the level of the polarity input.
- R11: With test MID and stop high, only banks whose code is LL rest (bank 3 included). All other banks keep their programmed waveform.
- R12: A change of enable takes effect only on an edge where the ungated value equals the rest level. High pulses of a skewed output therefore always last exactly 8 ticks, a low run lasts at least 8 ticks, and a stopped output holds its rest level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock, 16 ticks per nominal output period |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel_i | input | 16 | Four banks of two 2-bit three-level selects |
| soe_i | input | 1 | Synchronous stop request, active high |
| pe_i | input | 1 | Edge polarity: 1 rising, 0 falling reference edge |
| test_i | input | 2 | Three-level test-mode input; MID enables per-bank stop by LL |
| clk_o | output | 8 | Bank clock outputs, two pins per bank |

## Verification
Every output is one register past the phase count, so the value seen after edge k belongs to count k-1. The bench keeps its own count of edges since reset release and compares against the waveform formulas at that count, always sampling on the falling clock edge. A stop or select change may wait up to one 64-tick divided period before it settles. The bench therefore waits 72 edges after each stimulus and then compares a full 64-tick window. The pulse-width check watches every edge while the stop input toggles at odd times, so a single shortened pulse is enough to fail it.

// File: rtl/skew_pkg.sv
package skew_pkg;

  typedef enum logic [1:0] {
    MODE_SKEW = 2'd0,
    MODE_DIV2 = 2'd1,
    MODE_DIV4 = 2'd2,
    MODE_INV  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    KIND_FINE = 2'd0,
    KIND_DIV4 = 2'd1,
    KIND_INV  = 2'd2
  } kind_e;

  localparam logic [1:0] LVL_MID = 2'b01;
  localparam logic [3:0] IDX_LL  = 4'd0;
  localparam logic [3:0] IDX_HH  = 4'd8;

  // An undriven pin (11) reads as MID
  function automatic logic [1:0] level_of(input logic [1:0] pin);
    return (pin == 2'b11) ? LVL_MID : pin;
  endfunction

  // LL=0 ... HH=8, first letter weighted by three
  function automatic logic [3:0] code_index(input logic [3:0] sel);
    int hi, lo;
    hi = int'(level_of(sel[3:2]));
    lo = int'(level_of(sel[1:0]));
    return 4'(3 * hi + lo);
  endfunction

endpackage

// File: rtl/skew_select.sv
module skew_select
  import skew_pkg::*;
#(
  parameter kind_e KIND  = KIND_FINE,
  parameter int    SKW_W = 4
) (
  input  logic [3:0]              sel_i,
  output mode_e                   mode_o,
  output logic signed [SKW_W-1:0] skew_o,
  output logic                    is_ll_o
);

  logic [3:0] idx;
  int         off;

  always_comb begin
    idx     = code_index(sel_i);
    off     = int'(idx) - 4;
    is_ll_o = (idx == IDX_LL);
    mode_o  = MODE_SKEW;
    skew_o  = '0;
    if (KIND == KIND_FINE) begin
      skew_o = SKW_W'(off);
    end else if (idx == IDX_LL) begin
      mode_o = MODE_DIV2;
    end else if (idx == IDX_HH) begin
      mode_o = (KIND == KIND_DIV4) ? MODE_DIV4 : MODE_INV;
    end else begin
      skew_o = SKW_W'(2 * off);
    end
  end

endmodule

// File: rtl/skew_wave.sv
module skew_wave
  import skew_pkg::*;
#(
  parameter int PHASE_W = 4,
  parameter int CNT_W   = PHASE_W + 2,
  parameter int SKW_W   = PHASE_W
) (
  input  logic [CNT_W-1:0]        cnt_i,
  input  mode_e                   mode_i,
  input  logic signed [SKW_W-1:0] skew_i,
  input  logic                    pe_i,
  output logic                    raw_o,
  output logic                    stop_o
);

  localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (PHASE_W - 1);

  logic [CNT_W-1:0] skew_ext;
  logic [CNT_W-1:0] ph;
  logic [CNT_W-1:0] phd;

  always_comb begin
    skew_ext = {{(CNT_W-SKW_W){skew_i[SKW_W-1]}}, skew_i};
    ph       = cnt_i - skew_ext;
    phd      = pe_i ? cnt_i : (cnt_i - HALF);
    unique case (mode_i)
      MODE_SKEW: raw_o = ~ph[PHASE_W-1];
      MODE_DIV2: raw_o = ~phd[PHASE_W];
      MODE_DIV4: raw_o = ~phd[PHASE_W+1];
      MODE_INV:  raw_o = cnt_i[PHASE_W-1];
      default:   raw_o = 1'b0;
    endcase
    stop_o = (mode_i == MODE_INV) & pe_i;
  end

endmodule

// File: rtl/bank_gate.sv
module bank_gate (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic stop_i,
  input  logic want_i,
  output logic q_o
);

  logic en_q;
  logic en_nx;

  // Enable may only change where the ungated value is at the rest level
  always_comb en_nx = (raw_i == stop_i) ? want_i : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      q_o  <= 1'b0;
    end else begin
      en_q <= en_nx;
      q_o  <= en_nx ? raw_i : stop_i;
    end
  end

endmodule

// File: rtl/skew_clock_banks.sv
module skew_clock_banks
  import skew_pkg::*;
#(
  parameter int NBANK    = 4,
  parameter int PHASE_W  = 4,
  parameter int FB_BANK  = 2,
  parameter int INV_BANK = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [4*NBANK-1:0] bank_sel_i,
  input  logic               soe_i,
  input  logic               pe_i,
  input  logic [1:0]         test_i,
  output logic [2*NBANK-1:0] clk_o
);

  localparam int CNT_W = PHASE_W + 2;
  localparam int SKW_W = PHASE_W;

  logic [CNT_W-1:0] cnt_q;
  logic             test_mid;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + CNT_W'(1);
  end

  always_comb test_mid = (level_of(test_i) == LVL_MID);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam kind_e KIND = (b == FB_BANK)  ? KIND_DIV4 :
                             (b == INV_BANK) ? KIND_INV  : KIND_FINE;

    mode_e                   mode;
    logic signed [SKW_W-1:0] skew;
    logic                    is_ll;
    logic                    raw;
    logic                    stop;
    logic                    want;
    logic                    q;

    skew_select #(.KIND(KIND), .SKW_W(SKW_W)) u_sel (
      .sel_i   (bank_sel_i[4*b +: 4]),
      .mode_o  (mode),
      .skew_o  (skew),
      .is_ll_o (is_ll)
    );

    skew_wave #(.PHASE_W(PHASE_W), .CNT_W(CNT_W), .SKW_W(SKW_W)) u_wave (
      .cnt_i  (cnt_q),
      .mode_i (mode),
      .skew_i (skew),
      .pe_i   (pe_i),
      .raw_o  (raw),
      .stop_o (stop)
    );

    if (b == FB_BANK) begin : g_fb
      always_comb want = !(soe_i && test_mid && is_ll);
    end else begin : g_std
      always_comb want = !soe_i || (test_mid && !is_ll);
    end

    bank_gate u_gate (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (raw),
      .stop_i (stop),
      .want_i (want),
      .q_o    (q)
    );

    assign clk_o[2*b +: 2] = {q, q};
  end

endmodule

// File: rtl/skew_clock_banks_chk.sv
module skew_clock_banks_chk #(
  parameter int NBANK    = 4,
  parameter int INV_BANK = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [3:0]         sel0_i,
  input logic [3:0]         seli_i,
  input logic               soe_i,
  input logic               pe_i,
  input logic [1:0]         test_i,
  input logic [2*NBANK-1:0] clk_o
);

  logic gate_off;
  logic inv_off;

  always_comb begin
    gate_off = soe_i && (test_i != 2'b01) && (test_i != 2'b11);
    inv_off  = gate_off && (seli_i == 4'b1010);
  end

  // R1
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (clk_o == '0));

  // R12: once low under a stop, bank 1 stays low
  a_r12_stop_holds: assert property (@(posedge clk) disable iff (rst)
    ($past(gate_off) && !clk_o[0]) |=> !clk_o[0]);

  // R12: no one-tick high pulse on a skewed output
  a_r12_no_runt: assert property (@(posedge clk) disable iff (rst)
    ($rose(clk_o[0]) && $stable(sel0_i)) |=> clk_o[0]);

  // R10: a stopped inverted bank holds the polarity level
  a_r10_inv_rest: assert property (@(posedge clk) disable iff (rst)
    ($past(inv_off) && inv_off && $stable(pe_i) && (clk_o[2*INV_BANK] == pe_i))
      |=> (clk_o[2*INV_BANK] == $past(pe_i)));

endmodule

bind skew_clock_banks skew_clock_banks_chk #(.NBANK(NBANK), .INV_BANK(INV_BANK)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .sel0_i (bank_sel_i[3:0]),
  .seli_i (bank_sel_i[4*INV_BANK +: 4]),
  .soe_i  (soe_i),
  .pe_i   (pe_i),
  .test_i (test_i),
  .clk_o  (clk_o)
);

// File: tb/skew_clock_banks_tb.sv
`timescale 1ns/1ps
module skew_clock_banks_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bank_sel = 16'h5555;
  logic        soe = 1'b0;
  logic        pe = 1'b1;
  logic [1:0]  test = 2'b00;
  logic [7:0]  clk_o;

  int checks = 0;
  int failures = 0;
  int tick = 0;
  int cur_idx [4] = '{4, 4, 4, 4};
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) tick <= 0;
    else     tick <= tick + 1;
  end

  skew_clock_banks u_dut (
    .clk        (clk),
    .rst        (rst),
    .bank_sel_i (bank_sel),
    .soe_i      (soe),
    .pe_i       (pe),
    .test_i     (test),
    .clk_o      (clk_o)
  );

  task automatic chk(input string req, input bit ok, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Ungated waveform from R2..R7; c in 0..63
  function automatic logic wave(input int b, input int idx, input logic p, input int c);
    int s;
    int d;
    d = p ? 0 : 8;
    if (b < 2) begin
      s = idx - 4;
      return ((c - s + 64) % 16) < 8;
    end
    if (idx == 0) return ((c - d + 64) % 32) < 16;
    if (idx == 8) begin
      if (b == 2) return ((c - d + 64) % 64) < 32;
      return (c % 16) >= 8;
    end
    s = 2 * (idx - 4);
    return ((c - s + 64) % 16) < 8;
  endfunction

  // Enable per R9 and R11
  function automatic bit wanted(input int b, input int idx);
    bit mid;
    mid = (test == 2'b01) || (test == 2'b11);
    if (!soe) return 1'b1;
    if (mid)  return idx != 0;
    return b == 2;
  endfunction

  function automatic logic [7:0] expect_vec(input int c);
    logic [7:0] v;
    logic bit_v;
    for (int b = 0; b < 4; b++) begin
      if (wanted(b, cur_idx[b])) bit_v = wave(b, cur_idx[b], pe, c);
      else                       bit_v = (b == 3 && cur_idx[b] == 8) ? pe : 1'b0;
      v[2*b]   = bit_v;
      v[2*b+1] = bit_v;
    end
    return v;
  endfunction

  task automatic set_codes(input int i0, input int i1, input int i2, input int i3);
    int v [4];
    v = '{i0, i1, i2, i3};
    for (int b = 0; b < 4; b++) begin
      cur_idx[b] = v[b];
      bank_sel[4*b+2 +: 2] = 2'(v[b] / 3);
      bank_sel[4*b +: 2]   = 2'(v[b] % 3);
    end
  endtask

  // Settle 72 edges, then compare a 64-tick window
  task automatic compare_window(input string req);
    logic [7:0] e;
    logic [7:0] bad_a = '0;
    logic [7:0] bad_e = '0;
    bit ok = 1'b1;
    repeat (72) @(posedge clk);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      e = expect_vec((tick - 1) % 64);
      if (ok && clk_o !== e) begin
        ok = 1'b0;
        bad_a = clk_o;
        bad_e = e;
      end
    end
    chk(req, ok, bad_a, bad_e);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 reset", clk_o === 8'h00, clk_o, 8'h00);
    rst = 1'b0;
  endtask

  task automatic t_fine;
    for (int i = 0; i < 9; i++) begin
      set_codes(i, 8 - i, 4, 4);
      compare_window($sformatf("R2 R3 fine code %0d", i));
    end
  endtask

  task automatic t_coarse;
    for (int p = 1; p >= 0; p--) begin
      pe = p[0];
      for (int i = 0; i < 9; i++) begin
        set_codes(4, 4, i, i);
        compare_window($sformatf("R4 R5 R6 R7 coarse code %0d pe %0d", i, p));
      end
    end
    pe = 1'b1;
  endtask

  task automatic t_undriven;
    bank_sel = 16'hFFFF;
    cur_idx = '{4, 4, 4, 4};
    test = 2'b11;
    compare_window("R8 undriven reads MID");
    test = 2'b00;
  endtask

  task automatic t_stop;
    soe = 1'b1;
    for (int p = 0; p < 2; p++) begin
      pe = p[0];
      set_codes(2, 7, 3, 8);
      compare_window($sformatf("R9 R10 stop pe %0d", p));
    end
    set_codes(0, 4, 0, 0);
    compare_window("R9 feedback bank divided runs");
    set_codes(4, 4, 8, 5);
    compare_window("R9 feedback bank div4 runs");
    soe = 1'b0;
    pe = 1'b1;
  endtask

  task automatic t_test_mid;
    test = 2'b01;
    soe = 1'b1;
    set_codes(0, 5, 0, 3);
    compare_window("R11 test MID LL banks rest");
    set_codes(8, 0, 6, 0);
    compare_window("R11 test MID other pattern");
    soe = 1'b0;
    test = 2'b00;
  endtask

  task automatic t_no_runt;
    logic prev;
    int run = 0;
    bit started = 1'b0;
    int bad_hi = 0;
    int bad_lo = 0;
    int fb_edges = 0;
    logic fb_prev;
    set_codes(4, 4, 4, 4);
    soe = 1'b0;
    repeat (72) @(posedge clk);
    @(negedge clk);
    prev = clk_o[0];
    fb_prev = clk_o[4];
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (i % 13 == 6) soe = ~soe;
      if (clk_o[4] != fb_prev) fb_edges++;
      fb_prev = clk_o[4];
      if (clk_o[0] == prev) run++;
      else begin
        if (started) begin
          if (prev == 1'b1 && run != 8) bad_hi++;
          if (prev == 1'b0 && run < 8) bad_lo++;
        end
        started = 1'b1;
        run = 1;
      end
      prev = clk_o[0];
    end
    chk("R12 high pulse width", bad_hi == 0, 8'(bad_hi), 8'h00);
    chk("R12 low run width", bad_lo == 0, 8'(bad_lo), 8'h00);
    chk("R9 feedback toggles during stops", fb_edges > 40, 8'(fb_edges), 8'd41);
    soe = 1'b0;
  endtask

  initial begin
    t_reset();
    t_fine();
    t_coarse();
    t_undriven();
    t_stop();
    t_test_mid();
    t_no_runt();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule